// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two N-bit words with a single one-bit full-adder cell, working through the operands one bit per clock, least significant bit first. Each operand sits in its own shift register, and both are loaded in parallel while the block is idle. During a run both registers shift right once per cycle. The cell takes the low bit of each register and a registered carry. It forms one sum bit, and that bit enters the top of the first operand register. After N cycles that register holds the sum, and the carry flip-flop holds the carry out of the top bit. The same bit pattern serves unsigned and two's-complement operands.

Wider numbers are added one N-bit word at a time, starting with the least significant word. The caller keeps the carry flip-flop across words by raising the chain input with each start after the first. A K-word addition therefore takes K·N run cycles. The result is read in parallel from the first operand register. The final carry stays on its own output until the next accepted start.

Top module: `bsa_top`

## Requirements
- R1: While reset is asserted and after it is released, `sum_out` is zero, `carry_out` is 0, `busy` is 0 and `done` is 0.
- R2: A `load` pulse while idle and without `start` captures `opa_in` and `opb_in`. The cycle after the capturing edge, `sum_out` equals `opa_in`.
- R3: A `start` accepted while idle raises `busy` for exactly N cycles, starting on the cycle after the start edge. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R4: With `chain` low at start, when `done` is high, `sum_out` equals (A + B) mod 2^N and `carry_out` equals bit N of A + B, for unsigned and two's-complement patterns alike.
- R5: A start with `chain` low clears the carry flip-flop before the first bit, whatever carry the previous operation left behind.
- R6: A start with `chain` high keeps the previous carry, so the result is A + B + previous `carry_out`. This allows multi-word addition from the low word upward.
- R7: `load` is ignored while `busy` is high, and the result of the run in progress is unchanged.
- R8: `start` is ignored while `busy` is high. The run is not restarted, and `done` still comes N cycles after the original start.
- R9: While idle, `carry_out` and `sum_out` hold their values until a load or an accepted start.
- R10: When `load` and `start` are both high in an idle cycle, the start is taken and the load is ignored, so the run uses the operands loaded earlier.
- R11: Sum bits come out least significant first. After the first run cycle, `sum_out[N-1]` equals bit 0 of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel load of both operands (idle only) |
| opa_in | input | N | First operand, load value |
| opb_in | input | N | Second operand, load value |
| start | input | 1 | Begin an N-cycle addition (idle only) |
| chain | input | 1 | Sampled with start: 1 keeps the carry, 0 clears it |
| busy | output | 1 | High during the N run cycles |
| done | output | 1 | One-cycle pulse after the last bit |
| sum_out | output | N | Contents of the first operand register, which holds the result |
| carry_out | output | 1 | Carry flip-flop, which holds the final carry after a run |

## Verification
The assertions assume that `load`, `start` and `chain` are synchronous to `clk` and free of unknown values after reset. They also assume that `chain` matters only in the cycle where `start` is accepted. The stimulus drives every control input on the falling edge and returns each one to zero after a single cycle. It raises `load` and `start` during a run only on purpose, to show that they are ignored. Every operand pair comes from the table or from a directed corner case, so no input is ever left floating.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic logic bsa_xor3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic bsa_maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] data;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.data = {shift_in, st_q.data[W-1:1]};
        end else if (load_en) begin
            st_d.data = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.data;

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !shift_en) |=> (q == $past(load_val)));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(q));

    p_shift_in_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q[W-1] == $past(shift_in)));

endmodule

// File: rtl/bsa_fa_cell.sv
module bsa_fa_cell
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic step,
    input  logic clr,
    output logic sum_bit,
    output logic carry
);

    typedef struct packed {
        logic c;
    } fa_state_t;

    fa_state_t st_d, st_q;

    always_comb begin
        sum_bit = bsa_xor3(a_bit, b_bit, st_q.c);
        st_d    = st_q;
        if (clr) begin
            st_d.c = 1'b0;
        end else if (step) begin
            st_d.c = bsa_maj3(a_bit, b_bit, st_q.c);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry = st_q.c;

    p_carry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry);

    p_carry_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(carry));

    p_carry_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && a_bit && b_bit) |=> carry);

    p_carry_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !a_bit && !b_bit) |=> !carry);

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    st_d.ph  = PH_RUN;
                    st_d.cnt = '0;
                end
            end
            PH_RUN: begin
                if (st_q.cnt == LAST) begin
                    st_d.ph   = PH_IDLE;
                    st_d.cnt  = '0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step = (st_q.ph == PH_RUN);
    assign busy = (st_q.ph == PH_RUN);
    assign done = st_q.done;

    p_run_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt == LAST) |=> (done && !busy));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt != LAST) |=> (busy && st_q.cnt == $past(st_q.cnt) + 1'b1));

    p_start_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && st_q.cnt == '0));

endmodule

// File: rtl/bsa_top.sv
module bsa_top #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] opa_in,
    input  logic [N-1:0] opb_in,
    input  logic         start,
    input  logic         chain,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] sum_out,
    output logic         carry_out
);

    logic         accept;
    logic         step;
    logic         ld_en;
    logic         clr_c;
    logic         sbit;
    logic [N-1:0] a_q;
    logic [N-1:0] b_q;

    always_comb begin
        ld_en = load & ~busy & ~start;
        clr_c = accept & ~chain;
    end

    bsa_ctrl #(.N(N)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .step   (step),
        .busy   (busy),
        .done   (done)
    );

    bsa_shreg #(.W(N)) u_reg_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ld_en),
        .load_val (opa_in),
        .shift_en (step),
        .shift_in (sbit),
        .q        (a_q)
    );

    bsa_shreg #(.W(N)) u_reg_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ld_en),
        .load_val (opb_in),
        .shift_en (step),
        .shift_in (1'b0),
        .q        (b_q)
    );

    bsa_fa_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_bit   (a_q[0]),
        .b_bit   (b_q[0]),
        .step    (step),
        .clr     (clr_c),
        .sum_bit (sbit),
        .carry   (carry_out)
    );

    assign sum_out = a_q;

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !load) |=> ($stable(sum_out) && $stable(carry_out)));

    p_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |=> (sum_out[N-2:0] == $past(sum_out[N-1:1])));

    p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && load) |=> (busy && sum_out == $past(sum_out)));

endmodule

// File: tb/sim_bsa_top.sv
module sim_bsa_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [N-1:0] opa_in = '0;
    logic [N-1:0] opb_in = '0;
    logic         start = 1'b0;
    logic         chain = 1'b0;
    logic         busy;
    logic         done;
    logic [N-1:0] sum_out;
    logic         carry_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [15:0] VEC [0:6] = '{
        16'h12_34, 16'hFF_01, 16'h80_80, 16'hFD_05,
        16'h00_00, 16'hAA_55, 16'h7F_01
    };

    always #2.5 clk = ~clk;

    bsa_top #(.N(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .opa_in    (opa_in),
        .opb_in    (opb_in),
        .start     (start),
        .chain     (chain),
        .busy      (busy),
        .done      (done),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        load = 1'b1;
        opa_in = a;
        opb_in = b;
        @(negedge clk);
        load = 1'b0;
        chk("R2 load a", 32'(sum_out), 32'(a));
    endtask

    // mode 0 plain, 1 load during run, 2 start during run, 3 load with start
    task automatic run_op(input logic ch, input int mode,
                          input logic [N-1:0] exp_s, input logic exp_c);
        @(negedge clk);
        start = 1'b1;
        chain = ch;
        if (mode == 3) begin
            load = 1'b1;
            opa_in = 8'hC3;
            opb_in = 8'h3C;
        end
        @(negedge clk);
        start = 1'b0;
        chain = 1'b0;
        load = 1'b0;
        chk("R3 busy first", 32'(busy), 32'd1);
        for (int k = 1; k <= N; k++) begin
            @(negedge clk);
            if (k == 1) chk("R11 lsb first", 32'(sum_out[N-1]), 32'(exp_s[0]));
            if (k == 2 && mode == 1) begin
                load = 1'b1;
                opa_in = 8'hFF;
                opb_in = 8'hFF;
            end
            if (k == 2 && mode == 2) start = 1'b1;
            if (k == 3) begin
                load = 1'b0;
                start = 1'b0;
            end
            if (k == N - 1) begin
                chk("R3 busy last", 32'(busy), 32'd1);
                chk("R3 done early", 32'(done), 32'd0);
            end
        end
        chk("R3 done", 32'(done), 32'd1);
        chk("R3 busy end", 32'(busy), 32'd0);
        chk("R4 sum", 32'(sum_out), 32'(exp_s));
        chk("R4 carry", 32'(carry_out), 32'(exp_c));
        @(negedge clk);
        chk("R3 done pulse", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N:0] full;
        repeat (3) @(negedge clk);
        chk("R1 reset sum", 32'(sum_out), 32'd0);
        chk("R1 reset carry", 32'(carry_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sum", 32'(sum_out), 32'd0);
        chk("R1 carry", 32'(carry_out), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);

        // table walk, R4
        for (int i = 0; i < 7; i++) begin
            full = {1'b0, VEC[i][15:8]} + {1'b0, VEC[i][7:0]};
            do_load(VEC[i][15:8], VEC[i][7:0]);
            run_op(1'b0, 0, full[N-1:0], full[N]);
        end

        // R6: two-word chain 0x12FF + 0x3401 = 0x4700
        do_load(8'hFF, 8'h01);
        run_op(1'b0, 0, 8'h00, 1'b1);
        do_load(8'h12, 8'h34);
        run_op(1'b1, 0, 8'h47, 1'b0);

        // R6: chain with carry 1 into all ones -> 0x00 carry 1
        do_load(8'hFF, 8'h01);
        run_op(1'b0, 0, 8'h00, 1'b1);
        do_load(8'hFF, 8'h00);
        run_op(1'b1, 0, 8'h00, 1'b1);

        // R9: idle hold
        repeat (5) @(negedge clk);
        chk("R9 carry hold", 32'(carry_out), 32'd1);
        chk("R9 sum hold", 32'(sum_out), 32'd0);

        // R5: chain low clears stale carry
        do_load(8'h00, 8'h00);
        run_op(1'b0, 0, 8'h00, 1'b0);

        // R7: load during run ignored (0x21+0x43=0x64)
        do_load(8'h21, 8'h43);
        run_op(1'b0, 1, 8'h64, 1'b0);

        // R8: start during run ignored (0x90+0x90=0x120)
        do_load(8'h90, 8'h90);
        run_op(1'b0, 2, 8'h20, 1'b1);

        // R10: load and start together, start wins (0x0F+0x01)
        do_load(8'h0F, 8'h01);
        run_op(1'b0, 3, 8'h10, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule